// File: doc/BRIEF.md
# Trigger Busy and Interrupt Sequencer

This block is the acquisition controller of a multi-channel digitizer module. It watches an asynchronous trigger line, and every trigger it accepts produces one conversion start pulse shared by all channels. It also keeps a count of the events now held in the channel buffers. Once that count reaches a number that software has programmed, the block raises an interrupt and holds a busy line that vetoes any further trigger. Busy and the interrupt stay up until the readout software has drained the buffers and writes the clear bit of the control register. That write also produces a one-cycle pulse that empties the channel FIFOs.

Busy is also raised for the length of each conversion window, given in sample clocks by an input. This keeps a new trigger from landing on top of a conversion that is still running. The trigger input passes through a synchronizer, and only its rising edge counts. A trigger pulse of any width therefore counts as exactly one event.

Top module: `trigseq_top`

## Requirements
- R1: A rising edge on `trig_in` is accepted at most once, however long the line stays high. The conversion strobe of an accepted trigger appears at the third rising clock edge after `trig_in` goes high, and not before.
- R2: Each accepted trigger drives `conv_strobe` high for exactly one cycle and raises `evt_count` by one in that same cycle.
- R3: An accepted trigger holds `busy` high for `conv_len` cycles, starting with the strobe cycle. When `conv_len` is 0, no window busy is added.
- R4: Every control write loads the 5-bit event threshold. Bit 9 of `csr_wdata` is the most significant bit, and bits 3 to 0 are the four low bits. No other data bit has any effect on the threshold.
- R5: In the cycle where `evt_count` first reaches the threshold, `irq` and `busy` both go high, together with the strobe. A threshold of 0 behaves like 1, so an interrupt follows every event.
- R6: Once set, `irq` and the busy veto stay high until a clear write.
- R7: A trigger edge that arrives while `busy` is high is dropped. It gives no strobe and leaves `evt_count` unchanged.
- R8: A control write with bit 8 set has these effects in the next cycle: `evt_count` is 0, `irq` and `busy` are low, and `fifo_clear` is high for one cycle. A trigger accepted in the same cycle as the clear is discarded.
- R9: After reset, `busy`, `irq`, `conv_strobe`, `fifo_clear` and `evt_count` are all zero, and the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous external trigger |
| conv_len | input | 10 | Conversion window length in clocks |
| csr_wr | input | 1 | Control register write strobe |
| csr_wdata | input | 16 | Control register write data |
| conv_strobe | output | 1 | One-cycle conversion start for all channels |
| busy | output | 1 | Trigger veto |
| irq | output | 1 | Event threshold interrupt |
| fifo_clear | output | 1 | One-cycle channel FIFO clear |
| evt_count | output | 6 | Events stored since the last clear |

## Verification
The bench holds the trigger high for many cycles. A design that counts levels instead of edges would then record a burst of events. It also checks where the strobe lands relative to the synchronizer, so a missing or extra stage shows up as a strobe one cycle early or late. Triggers sent during the busy veto must leave the count untouched, because a leaky veto would overfill the buffers. A clear write that coincides with an accepted edge must win, or a stale event would survive the reset. The threshold field is written with every unrelated bit set. A wrong bit mapping would move the interrupt away from the sixteenth event, and a zero threshold that is not treated as one would never interrupt.

// File: rtl/trigseq_pkg.sv
package trigseq_pkg;
    localparam int CSR_W      = 16;
    localparam int THR_W      = 5;
    localparam int THR_LO_W   = 4;
    localparam int THR_LO_POS = 0;
    localparam int THR_HI_POS = 9;
    localparam int CLR_POS    = 8;
    localparam int CNT_W      = 6;
    localparam int WIN_W      = 10;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq;
        logic             hold;
    } ev_state_t;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             strobe;
        logic             fifo_clr;
    } top_state_t;
endpackage

// File: rtl/trigseq_edge.sv
module trigseq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.chain[STAGES-1] & ~st_q.last;

    // a detected edge lasts one cycle only
    assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/trigseq_window.sv
module trigseq_window #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         clear,
    input  logic [W-1:0] len,
    output logic         active
);
    typedef struct packed {
        logic [W-1:0] remain;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)
            st_d.remain = '0;
        else if (start)
            st_d.remain = len;
        else if (st_q.remain != '0)
            st_d.remain = st_q.remain - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.remain != '0);

    assert_window_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear && len != '0) |=> active);
    assert_window_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear && len == '0) |=> !active);
endmodule

// File: rtl/trigseq_evcount.sv
module trigseq_evcount
    import trigseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             clear,
    input  logic [THR_W-1:0] thr,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             hold
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ev_state_t st_d, st_q;
    logic [CNT_W-1:0] goal;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        goal = (thr == '0) ? ONE : CNT_W'(thr);
        nxt  = st_q.count + ONE;
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (accept) begin
            st_d.count = nxt;
            if (nxt >= goal) begin
                st_d.irq  = 1'b1;
                st_d.hold = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign irq   = st_q.irq;
    assign hold  = st_q.hold;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clear) |=> count == $past(count) + ONE);
    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear) |=> irq);
    assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clear) |=> hold);
endmodule

// File: rtl/trigseq_top.sv
module trigseq_top
    import trigseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [WIN_W-1:0] conv_len,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic             conv_strobe,
    output logic             busy,
    output logic             irq,
    output logic             fifo_clear,
    output logic [CNT_W-1:0] evt_count
);
    top_state_t st_d, st_q;
    logic rise, clr_req, accept, hold, win_active;

    trigseq_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise(rise)
    );

    assign clr_req = csr_wr & csr_wdata[CLR_POS];
    assign busy    = hold | win_active;
    assign accept  = rise & ~busy & ~clr_req;

    trigseq_window #(.W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .start(accept), .clear(clr_req),
        .len(conv_len), .active(win_active)
    );

    trigseq_evcount u_ev (
        .clk(clk), .rst_n(rst_n), .accept(accept), .clear(clr_req),
        .thr(st_q.thr), .count(evt_count), .irq(irq), .hold(hold)
    );

    always_comb begin
        st_d          = st_q;
        st_d.strobe   = accept;
        st_d.fifo_clr = clr_req;
        if (csr_wr)
            st_d.thr = {csr_wdata[THR_HI_POS],
                        csr_wdata[THR_LO_POS +: THR_LO_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_strobe = st_q.strobe;
    assign fifo_clear  = st_q.fifo_clr;

    assert_veto_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !conv_strobe);
    assert_irq_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (!busy && !irq && evt_count == '0 && fifo_clear && !conv_strobe));
    assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> !conv_strobe);
endmodule

// File: tb/trigseq_top_test.sv
module trigseq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic [9:0]  conv_len = '0;
    logic        csr_wr = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic        conv_strobe, busy, irq, fifo_clear;
    logic [5:0]  evt_count;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    trigseq_top uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .conv_len(conv_len),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .conv_strobe(conv_strobe),
        .busy(busy), .irq(irq), .fifo_clear(fifo_clear), .evt_count(evt_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [15:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    // one trigger pulse; checks strobe timing and count (R1, R2)
    task automatic fire(input int exp_cnt);
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); chk("R1 strobe early n1", conv_strobe, 0);
        @(negedge clk); chk("R1 strobe early n2", conv_strobe, 0);
        @(negedge clk); chk("R2 strobe", conv_strobe, 1);
        chk("R2 count", evt_count, exp_cnt);
        trig_in = 1'b0;
        @(negedge clk); chk("R2 strobe one cycle", conv_strobe, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R9 busy", busy, 0);
        chk("R9 irq", irq, 0);
        chk("R9 strobe", conv_strobe, 0);
        chk("R9 fifo_clear", fifo_clear, 0);
        chk("R9 count", evt_count, 0);
    endtask

    task automatic t_window;
        @(negedge clk); csr_wr = 1'b1; csr_wdata = 16'h0103;
        @(negedge clk); csr_wr = 1'b0; csr_wdata = '0;
        chk("R8 fifo_clear pulse", fifo_clear, 1);
        @(negedge clk); chk("R8 fifo_clear ends", fifo_clear, 0);
        conv_len = 10'd4;
        @(negedge clk); trig_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 busy on strobe", busy, 1);
        chk("R2 count window", evt_count, 1);
        trig_in = 1'b0;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk); chk("R3 busy in window", busy, 1);
        end
        @(negedge clk); chk("R3 busy window end", busy, 0);
        chk("R5 no irq early", irq, 0);
        conv_len = 10'd0;
    endtask

    task automatic t_threshold;
        fire(2);
        chk("R3 no window for len 0", busy, 0);
        chk("R5 irq below threshold", irq, 0);
        @(negedge clk); trig_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 irq at threshold", irq, 1);
        chk("R5 busy at threshold", busy, 1);
        chk("R5 count", evt_count, 3);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_veto;
        int seen = 0;
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); trig_in = 1'b1;
            repeat (3) begin @(negedge clk); if (conv_strobe) seen++; end
            trig_in = 1'b0;
            repeat (3) begin @(negedge clk); if (conv_strobe) seen++; end
        end
        chk("R7 no strobe while busy", seen, 0);
        chk("R7 count unchanged", evt_count, 3);
        repeat (20) @(negedge clk);
        chk("R6 irq held", irq, 1);
        chk("R6 busy held", busy, 1);
    endtask

    task automatic t_clear_race;
        csr_write(16'h0100);
        chk("R8 busy cleared", busy, 0);
        csr_write(16'h000A);
        chk("R8 count cleared", evt_count, 0);
        chk("R8 irq cleared", irq, 0);
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk);
        @(negedge clk); csr_wr = 1'b1; csr_wdata = 16'h010A;
        @(negedge clk); csr_wr = 1'b0; csr_wdata = '0;
        chk("R8 clear beats trigger strobe", conv_strobe, 0);
        chk("R8 clear beats trigger count", evt_count, 0);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_held;
        int seen = 0;
        @(negedge clk); trig_in = 1'b1;
        repeat (30) begin @(negedge clk); if (conv_strobe) seen++; end
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 held trigger strobes", seen, 1);
        chk("R1 held trigger count", evt_count, 1);
    endtask

    task automatic t_zero;
        csr_write(16'h0100);
        @(negedge clk); trig_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 zero threshold irq", irq, 1);
        chk("R5 zero threshold count", evt_count, 1);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_field;
        // all bits set except bits 3..0: threshold becomes 16, clear also applied
        csr_write(16'hFFF0);
        for (int n = 1; n <= 15; n++) fire(n);
        chk("R4 no irq before 16", irq, 0);
        fire(16);
        chk("R4 irq at 16", irq, 1);
        csr_write(16'h0100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_window();
        t_threshold();
        t_veto();
        t_clear_race();
        t_held();
        t_zero();
        t_field();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule